// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block receives an instruction stream one byte at a time and rebuilds complete instructions for a small load/store machine. Each instruction starts with a one-byte opcode. A destination operand byte and a first source operand byte always follow the opcode. A second source operand byte comes last, but only when the opcode asks for it. The instruction carries no length field: the opcode alone sets how many bytes belong to it.

For each finished instruction the block presents the following outputs:
- the opcode and the operands;
- a flag that gives the operand count;
- the length in bytes;
- the execution latency of the instruction's class. This latency already includes the extra decode cost of the variable-length format.

Bytes enter through a valid/ready handshake. The finished instruction leaves through a second valid/ready handshake. While an instruction waits to be accepted, the input is stalled.

Top module: `vlen_parser`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the next accepted byte is taken as an opcode.
- R2: An opcode with bit 7 set to 1 gives a four-byte instruction. After it, `out_three` is 1 and `out_len` is 4.
- R3: An opcode with bit 7 set to 0 gives a three-byte instruction. After it, `out_three` is 0, `out_len` is 3 and `out_src2` is 0, whatever an earlier instruction left in that slot.
- R4: Accepted bytes are placed in order: first `out_opcode`, then `out_dst`, then `out_src1`, then `out_src2` when it is present.
- R5: `out_lat` is 6 when opcode bit 6 is 1 (load/store class) and 3 when it is 0 (register or immediate class).
- R6: Once `out_valid` is 1, it stays 1 and all output fields stay unchanged until a clock edge where `out_ready` is 1. `out_valid` is 0 after that edge.
- R7: `in_ready` is 0 whenever `out_valid` is 1. A byte offered during that time is not consumed, and it is taken later as the first byte of the next instruction.
- R8: Cycles where `in_valid` is 0 between bytes do not disturb framing.
- R9: `out_valid` rises at the clock edge that completes the handshake of an instruction's last byte. It is 0 before that edge.
- R10: Asserting reset in the middle of an instruction discards the partial instruction. The first byte accepted after reset is an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | An input byte is offered |
| in_ready | output | 1 | The parser can take a byte |
| in_byte | input | 8 | Input stream byte |
| out_valid | output | 1 | A complete instruction is presented |
| out_ready | input | 1 | The consumer takes the instruction |
| out_opcode | output | 8 | Opcode byte |
| out_dst | output | 8 | Destination operand |
| out_src1 | output | 8 | First source operand |
| out_src2 | output | 8 | Second source operand, 0 when absent |
| out_three | output | 1 | 1 = three operands, 0 = two operands |
| out_len | output | 3 | Instruction length in bytes (3 or 4) |
| out_lat | output | 3 | Class latency in cycles (3 or 6) |

## Verification
The assertions assume that the consumer may hold `out_ready` low for any number of cycles. They also assume that `in_valid` may be offered even while the input is stalled, so the bench holds `in_valid` high across a stalled output to cover that case. The checks of output stability and of the rising edge of valid assume that `rst_n` stays high between instructions. Because reset is released through two synchronizing flops, the bench waits several cycles after each release before it offers a byte, so no byte arrives during the synchronization window.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  typedef enum logic [1:0] {
    SLOT_OPC  = 2'd0,
    SLOT_DST  = 2'd1,
    SLOT_SRC1 = 2'd2,
    SLOT_SRC2 = 2'd3
  } vlp_slot_e;
endpackage

// File: rtl/vlp_rst_sync.sv
module vlp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/vlp_decode.sv
module vlp_decode #(
  parameter int BYTE_W    = 8,
  parameter int THREE_BIT = 7,
  parameter int MEM_BIT   = 6,
  parameter int LEN_W     = 3,
  parameter int LAT_W     = 3,
  parameter int LAT_ALU   = 3,
  parameter int LAT_MEM   = 6
) (
  input  logic [BYTE_W-1:0] opcode,
  output logic              three,
  output logic [LEN_W-1:0]  len,
  output logic [LAT_W-1:0]  lat
);
  localparam int BaseLen = 3;

  always_comb begin
    three = opcode[THREE_BIT];
    len   = three ? LEN_W'(BaseLen + 1) : LEN_W'(BaseLen);
    lat   = opcode[MEM_BIT] ? LAT_W'(LAT_MEM) : LAT_W'(LAT_ALU);
  end
endmodule

// File: rtl/vlp_frame.sv
module vlp_frame
  import vlp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       out_ready,
  input  logic       opc_three,
  output logic       in_ready,
  output logic       out_valid,
  output logic [3:0] slot_we
);
  vlp_slot_e slot_q, slot_d;
  logic      ov_q, ov_d;
  logic      take, last;

  always_comb begin
    in_ready = ~ov_q;
    take     = in_valid & in_ready;
    last     = (slot_q == SLOT_SRC2) | ((slot_q == SLOT_SRC1) & ~opc_three);
    slot_d   = slot_q;
    slot_we  = '0;
    if (take) begin
      case (slot_q)
        SLOT_OPC:  begin slot_we[0] = 1'b1; slot_d = SLOT_DST; end
        SLOT_DST:  begin slot_we[1] = 1'b1; slot_d = SLOT_SRC1; end
        SLOT_SRC1: begin slot_we[2] = 1'b1; slot_d = opc_three ? SLOT_SRC2 : SLOT_OPC; end
        default:   begin slot_we[3] = 1'b1; slot_d = SLOT_OPC; end
      endcase
    end
    ov_d = ov_q;
    if (take && last)         ov_d = 1'b1;
    else if (ov_q && out_ready) ov_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_OPC;
      ov_q   <= 1'b0;
    end else begin
      slot_q <= slot_d;
      ov_q   <= ov_d;
    end
  end

  assign out_valid = ov_q;
endmodule

// File: rtl/vlp_fields.sv
module vlp_fields #(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOTS-1:0]        we,
  input  logic                    clr_last,
  input  logic [BYTE_W-1:0]       din,
  output logic [SLOTS*BYTE_W-1:0] fields
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [BYTE_W-1:0] q, d;
    logic              en;

    if (i == SLOTS-1) begin : g_opt
      always_comb begin
        en = we[i] | clr_last;
        d  = we[i] ? din : '0;
      end
    end else begin : g_fix
      always_comb begin
        en = we[i];
        d  = din;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign fields[i*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/vlen_parser.sv
module vlen_parser #(
  parameter int BYTE_W    = 8,
  parameter int THREE_BIT = 7,
  parameter int MEM_BIT   = 6,
  parameter int LEN_W     = 3,
  parameter int LAT_W     = 3,
  parameter int LAT_ALU   = 3,
  parameter int LAT_MEM   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_opcode,
  output logic [BYTE_W-1:0] out_dst,
  output logic [BYTE_W-1:0] out_src1,
  output logic [BYTE_W-1:0] out_src2,
  output logic              out_three,
  output logic [LEN_W-1:0]  out_len,
  output logic [LAT_W-1:0]  out_lat
);
  localparam int Slots = 4;

  logic                    srst_n;
  logic [Slots-1:0]        slot_we;
  logic [Slots*BYTE_W-1:0] fields;

  vlp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  vlp_decode #(
    .BYTE_W(BYTE_W), .THREE_BIT(THREE_BIT), .MEM_BIT(MEM_BIT),
    .LEN_W(LEN_W), .LAT_W(LAT_W), .LAT_ALU(LAT_ALU), .LAT_MEM(LAT_MEM)
  ) u_dec (
    .opcode(out_opcode), .three(out_three), .len(out_len), .lat(out_lat)
  );

  vlp_frame u_frame (
    .clk(clk), .rst_n(srst_n), .in_valid(in_valid), .out_ready(out_ready),
    .opc_three(out_three), .in_ready(in_ready), .out_valid(out_valid),
    .slot_we(slot_we)
  );

  vlp_fields #(.BYTE_W(BYTE_W), .SLOTS(Slots)) u_fields (
    .clk(clk), .rst_n(srst_n), .we(slot_we), .clr_last(slot_we[0]),
    .din(in_byte), .fields(fields)
  );

  assign out_opcode = fields[0*BYTE_W +: BYTE_W];
  assign out_dst    = fields[1*BYTE_W +: BYTE_W];
  assign out_src1   = fields[2*BYTE_W +: BYTE_W];
  assign out_src2   = fields[3*BYTE_W +: BYTE_W];
endmodule

// File: rtl/vlen_parser_chk.sv
module vlen_parser_chk #(
  parameter int BYTE_W  = 8,
  parameter int LEN_W   = 3,
  parameter int LAT_W   = 3,
  parameter int MEM_BIT = 6,
  parameter int LAT_ALU = 3,
  parameter int LAT_MEM = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_opcode,
  input logic [BYTE_W-1:0] out_dst,
  input logic [BYTE_W-1:0] out_src1,
  input logic [BYTE_W-1:0] out_src2,
  input logic              out_three,
  input logic [LEN_W-1:0]  out_len,
  input logic [LAT_W-1:0]  out_lat
);
  // R7
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) && $stable(out_dst)
                                   && $stable(out_src1) && $stable(out_src2)));

  // R6
  drop_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  // R2
  four_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_three) |-> (out_len == LEN_W'(4)));

  // R3
  three_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_three) |-> (out_len == LEN_W'(3) && out_src2 == '0));

  // R5
  mem_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_opcode[MEM_BIT]) |-> (out_lat == LAT_W'(LAT_MEM)));

  // R5
  alu_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_opcode[MEM_BIT]) |-> (out_lat == LAT_W'(LAT_ALU)));

  // R9
  rise_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind vlen_parser vlen_parser_chk #(
  .BYTE_W(BYTE_W), .LEN_W(LEN_W), .LAT_W(LAT_W), .MEM_BIT(MEM_BIT),
  .LAT_ALU(LAT_ALU), .LAT_MEM(LAT_MEM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
  .out_dst(out_dst), .out_src1(out_src1), .out_src2(out_src2),
  .out_three(out_three), .out_len(out_len), .out_lat(out_lat)
);

// File: tb/test_vlen_parser.sv
`timescale 1ns/1ps
module test_vlen_parser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_opcode, out_dst, out_src1, out_src2;
  logic       out_three;
  logic [2:0] out_len, out_lat;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  vlen_parser i_vlen_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_dst(out_dst), .out_src1(out_src1),
    .out_src2(out_src2), .out_three(out_three), .out_len(out_len),
    .out_lat(out_lat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one byte, optional idle gap before it; checks out_valid against last
  task automatic send_byte(input logic [7:0] b, input int gap, input bit is_last);
    repeat (gap) @(negedge clk);
    check(out_valid == 1'b0, "R9 valid before last byte", out_valid, 0);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (is_last) check(out_valid == 1'b1, "R9 valid after last byte", out_valid, 1);
  endtask

  task automatic send_instr(input logic [7:0] op, d, s1, s2, input int gap);
    send_byte(op, gap, 1'b0);
    send_byte(d, gap, 1'b0);
    send_byte(s1, gap, !op[7]);
    if (op[7]) send_byte(s2, gap, 1'b1);
  endtask

  task automatic recv(input logic [7:0] op, d, s1, s2, input int hold);
    logic [7:0] es2;
    es2 = op[7] ? s2 : 8'h00;
    check(out_valid == 1'b1, "R6 valid present", out_valid, 1);
    check(out_opcode == op && out_dst == d && out_src1 == s1, "R4 byte order",
          {out_opcode, out_dst, out_src1}, {op, d, s1});
    check(out_src2 == es2, op[7] ? "R4 src2 slot" : "R3 src2 zero", out_src2, es2);
    check(out_three == op[7], op[7] ? "R2 three flag" : "R3 two flag", out_three, op[7]);
    check(out_len == (op[7] ? 3'd4 : 3'd3), op[7] ? "R2 length" : "R3 length",
          out_len, op[7] ? 4 : 3);
    check(out_lat == (op[6] ? 3'd6 : 3'd3), "R5 latency", out_lat, op[6] ? 6 : 3);
    repeat (hold) begin
      @(negedge clk);
      check(out_valid && out_opcode == op && out_src1 == s1 && out_src2 == es2,
            "R6 held output", out_opcode, op);
      check(in_ready == 1'b0, "R7 input stalled", in_ready, 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R6 valid dropped", out_valid, 0);
    check(in_ready == 1'b1, "R7 input resumes", in_ready, 1);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    send_instr(8'h12, 8'h03, 8'h01, 8'h00, 0);
    recv(8'h12, 8'h03, 8'h01, 8'h00, 0);
  endtask

  task automatic t_mix();
    send_instr(8'h81, 8'h03, 8'h01, 8'h02, 0);
    recv(8'h81, 8'h03, 8'h01, 8'h02, 2);
    send_instr(8'h45, 8'h05, 8'h0A, 8'h00, 0);
    recv(8'h45, 8'h05, 8'h0A, 8'h00, 0);
    send_instr(8'hC7, 8'h03, 8'h05, 8'h09, 0);
    recv(8'hC7, 8'h03, 8'h05, 8'h09, 1);
    // R3: src2 slot cleared after a three-operand instruction
    send_instr(8'h20, 8'h07, 8'h08, 8'h00, 0);
    recv(8'h20, 8'h07, 8'h08, 8'h00, 0);
  endtask

  task automatic t_gaps();
    // R8
    send_instr(8'hB3, 8'hA1, 8'hA2, 8'hA3, 3);
    recv(8'hB3, 8'hA1, 8'hA2, 8'hA3, 0);
    send_instr(8'h5E, 8'hB1, 8'hB2, 8'h00, 2);
    recv(8'h5E, 8'hB1, 8'hB2, 8'h00, 0);
  endtask

  task automatic t_stall();
    send_instr(8'h81, 8'h11, 8'h22, 8'h33, 0);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'h12;
    repeat (3) begin
      @(negedge clk);
      check(in_ready == 1'b0 && out_opcode == 8'h81, "R7 offered byte held off",
            out_opcode, 8'h81);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R6 drop during stall", out_valid, 0);
    @(negedge clk);
    in_valid = 1'b0;
    send_byte(8'h44, 0, 1'b0);
    send_byte(8'h55, 0, 1'b1);
    recv(8'h12, 8'h44, 8'h55, 8'h00, 0);
  endtask

  task automatic t_mid_reset();
    send_byte(8'h90, 0, 1'b0);
    send_byte(8'h66, 0, 1'b0);
    do_reset();
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10 idle after reset", out_valid, 0);
    send_instr(8'h03, 8'h0C, 8'h0D, 8'h00, 0);
    recv(8'h03, 8'h0C, 8'h0D, 8'h00, 0);
  endtask

  initial begin
    t_reset_state();
    t_mix();
    t_gaps();
    t_stall();
    t_mid_reset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule